// File: doc/BRIEF.md
# SPI Register Transaction Master with Flow-Control Wait States

This block performs one register access, read or write, to a security-module-style peripheral over a four-wire SPI link, acting as the bus master. A client offers a request with a direction, a byte count of 1 to 64 and a 24-bit register address. The block lowers chip select and sends a four-byte command header. It then clocks dummy bytes until the peripheral signals that it is ready. After that it moves the payload and raises chip select again.

Write payload comes from a simple byte source. The block samples `wr_data` at the start of each payload byte and pulses `wr_take` once that byte has been taken. Read payload leaves as a byte stream on `rd_data`/`rd_valid`. A one-cycle `done` pulse closes every request, with `err_code` telling success, a refused length, or an abort because the peripheral stalled too long. SCLK runs in SPI mode 0. Its half period is set by `cfg_div`, and a guaranteed idle time with chip select high separates consecutive transactions.

Top module: `spi_regxact_master`

## Requirements
- R1: The first header byte is {dir, 1, len-1}: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 hold the byte count minus one.
- R2: Header bytes two to four carry `req_addr`, most significant byte first.
- R3: A request whose `req_len` is 0 or above 64 is refused: `done` pulses in the cycle after acceptance with `err_code` = 2'b01, chip select never falls and no payload moves.
- R4: Chip select stays low without a break from before the first header bit to after the last payload bit. It rises in the same cycle that `done` pulses. SCLK never goes high while chip select is high.
- R5: After the header the master sends 8'h00 dummy bytes, one at a time. It stops polling after the first received byte whose bit 0 is 1, and the other bits of a received poll byte have no effect.
- R6: For a read, each payload byte that arrives after the ready byte appears on `rd_data` with a one-cycle `rd_valid`, in arrival order. MOSI carries 8'h00 during these bytes. A successful transaction ends with `err_code` = 2'b00.
- R7: For a write, each payload byte is the value on `wr_data` when that byte starts. `wr_take` pulses once per byte, one cycle after the byte is taken, and the source then advances to the next byte.
- R8: With `cfg_poll_limit` = N > 0, receiving N stall bytes in a row aborts the transaction. Chip select rises, `done` pulses with `err_code` = 2'b10, and no payload byte is clocked. N = 0 means poll without limit. N stall bytes followed by a ready byte still succeed when the limit is N+1.
- R9: SPI mode 0 is used. SCLK idles low, the peripheral samples on the rising edge, bits go MSB first, and every SCLK high phase lasts exactly `cfg_div`+1 clock cycles.
- R10: Between the rise of chip select and its next fall there are at least 2 SCLK periods, that is at least 4*(`cfg_div`+1) clock cycles.
- R11: `req_ready` is high only while idle. `busy` is high from acceptance until chip select rises and is never high together with `req_ready`. A request offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 8 | SCLK half period minus one, in clock cycles |
| cfg_poll_limit | input | 16 | Stall bytes tolerated before abort, 0 = unlimited |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_len | input | 7 | Payload byte count, legal 1 to 64 |
| req_addr | input | 24 | Register address |
| wr_data | input | 8 | Current write payload byte |
| wr_take | output | 1 | Pulse: write byte consumed, advance source |
| rd_data | output | 8 | Received read payload byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pulse: request finished |
| err_code | output | 2 | Result held from `done`: 00 ok, 01 bad length, 10 poll timeout |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Peripheral data in |

## Verification
The bench places a bit-level peripheral model on the link that stalls for a chosen number of bytes. Its stall bytes have every bit set except bit 0, so a design that tested the wrong bit or the whole byte would either never leave polling or leave it too early. The bench drives transaction lengths of 1 and 64 and the illegal lengths 0 and 65, where an off-by-one in the length field or the range test shows up as a wrong header byte or a chip select that falls when it should not. A poll limit equal to the stall count must abort with exactly seven bytes on the wire, while a limit one higher must succeed, which exposes an early or late comparison. Back-to-back requests and a request offered mid-transfer show up a chip-select gap that is too short and a handshake that accepts while busy.

// File: rtl/spi_regxact_pkg.sv
// Package: shared types and constants for the SPI register transaction master.
// Assumes: the header is always four bytes and the length field is six bits wide.
package spi_regxact_pkg;

    localparam int HDR_BYTES   = 4;
    localparam int LEN_FIELD_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HDR,
        ST_POLL,
        ST_DATA,
        ST_GAP
    } xact_state_e;

    typedef enum logic [1:0] {
        XERR_NONE = 2'b00,
        XERR_LEN  = 2'b01,
        XERR_POLL = 2'b10
    } xact_err_e;

endpackage

// File: rtl/spi_halfbit_timer.sv
// Module: produces a one-cycle tick every (div+1) clock cycles while enabled.
// Assumes: the count restarts from zero whenever en is low, so the first tick
// after enabling comes a full half period later.
module spi_halfbit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick when the count reaches the programmed half period.
    assign tick = en && (cnt == div);

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: with a divider above zero, two ticks never come back to back.
    a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(tick) && (div != '0)) |-> !tick);

endmodule

// File: rtl/spi_byte_shifter.sv
// Module: moves one byte in SPI mode 0, MSB first. The peripheral samples on the
// rising SCLK edge and data changes on the falling edge.
// Assumes: start is ignored while a byte is in flight; the byte ends on the
// falling edge after the eighth rise, when byte_done pulses with rx_byte valid.
module spi_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       active
);

    logic [7:0] tx_sh;
    logic [2:0] bit_cnt;

    // Load a byte, then alternate rising and falling SCLK phases on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                tx_sh   <= tx_byte;
                mosi    <= tx_byte[7];
                sclk    <= 1'b0;
                bit_cnt <= '0;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        mosi    <= tx_sh[6];
                    end
                end
            end
        end
    end

    // R9: SCLK only changes level on a timer tick.
    a_r9_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> $past(tick));

    // R9: a byte ends with SCLK back low, right after a high phase.
    a_r9_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!sclk && $past(sclk)));

endmodule

// File: rtl/spi_regxact_master.sv
// Module: runs one register read or write over SPI as master: a four-byte header,
// byte-wise flow-control polling, then up to MAX_BYTES of payload.
// Assumes: cfg_div and cfg_poll_limit are changed only while req_ready is high;
// wr_data holds the current write byte until wr_take pulses.
module spi_regxact_master
    import spi_regxact_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int POLL_W    = 16,
    parameter int MAX_BYTES = 64,
    parameter int GAP_SCLKS = 2,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [POLL_W-1:0] cfg_poll_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [23:0]       req_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_take,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int GAP_TICKS = 2 * GAP_SCLKS;
    localparam int GAP_CNT_W = $clog2(GAP_TICKS + 1);

    xact_state_e          state;
    logic                 cur_read;
    logic [LEN_W-1:0]     cur_len;
    logic [23:0]          cur_addr;
    logic [LEN_W-1:0]     idx;
    logic [POLL_W-1:0]    stall_cnt;
    logic [GAP_CNT_W-1:0] gap_cnt;
    logic                 cs_n_q;

    logic                 tick;
    logic                 timer_en;
    logic                 sh_start;
    logic [7:0]           sh_tx;
    logic                 sh_done;
    logic                 sh_active;
    logic                 sh_sclk;
    logic                 sh_mosi;
    logic [7:0]           sh_rx;
    logic                 pay_start;

    logic                 len_ok;
    logic [LEN_FIELD_W-1:0] len_field;
    logic [1:0]           hdr_sel;
    logic [7:0]           hdr_byte;
    logic                 stall_hit;
    logic                 last_payload;

    // Half-period timer runs during the lead-in, each byte and the CS-high gap.
    assign timer_en = sh_active || (state == ST_LEAD) || (state == ST_GAP);

    spi_halfbit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (timer_en),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_byte_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (sh_sclk),
        .mosi      (sh_mosi),
        .rx_byte   (sh_rx),
        .byte_done (sh_done),
        .active    (sh_active)
    );

    // Request length must be inside 1..MAX_BYTES.
    assign len_ok = (req_len != '0) && (req_len <= LEN_W'(MAX_BYTES));

    // Length field of the header is the byte count minus one.
    assign len_field = LEN_FIELD_W'(cur_len - LEN_W'(1));

    // Header byte index to launch next: byte 0 from lead-in, idx+1 after each header byte.
    assign hdr_sel = (state == ST_HDR) ? (idx[1:0] + 2'd1) : 2'd0;

    // Poll limit reached when this stall would be the N-th in a row.
    assign stall_hit = (cfg_poll_limit != '0) &&
                       (({1'b0, stall_cnt} + (POLL_W+1)'(1)) == {1'b0, cfg_poll_limit});

    // Current payload byte is the final one.
    assign last_payload = (idx == (cur_len - LEN_W'(1)));

    // Select the header byte content for the chosen position.
    always_comb begin
        case (hdr_sel)
            2'd0:    hdr_byte = {cur_read, 1'b1, len_field};
            2'd1:    hdr_byte = cur_addr[23:16];
            2'd2:    hdr_byte = cur_addr[15:8];
            default: hdr_byte = cur_addr[7:0];
        endcase
    end

    // Decide when to launch the next byte on the wire and what it carries.
    always_comb begin
        sh_start  = 1'b0;
        sh_tx     = 8'h00;
        pay_start = 1'b0;
        case (state)
            ST_LEAD: begin
                if (tick) begin
                    sh_start = 1'b1;
                    sh_tx    = hdr_byte;
                end
            end
            ST_HDR: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    sh_tx    = (idx == LEN_W'(HDR_BYTES - 1)) ? 8'h00 : hdr_byte;
                end
            end
            ST_POLL: begin
                if (sh_done) begin
                    if (sh_rx[0]) begin
                        sh_start  = 1'b1;
                        pay_start = 1'b1;
                        sh_tx     = cur_read ? 8'h00 : wr_data;
                    end else if (!stall_hit) begin
                        sh_start = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (sh_done && !last_payload) begin
                    sh_start  = 1'b1;
                    pay_start = 1'b1;
                    sh_tx     = cur_read ? 8'h00 : wr_data;
                end
            end
            default: ;
        endcase
    end

    // Transaction sequencer: accept, header, poll, payload, CS-high gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cs_n_q    <= 1'b1;
            done      <= 1'b0;
            err_code  <= XERR_NONE;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            wr_take   <= 1'b0;
            cur_read  <= 1'b0;
            cur_len   <= '0;
            cur_addr  <= '0;
            idx       <= '0;
            stall_cnt <= '0;
            gap_cnt   <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            wr_take  <= pay_start && !cur_read;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!len_ok) begin
                            done     <= 1'b1;
                            err_code <= XERR_LEN;
                        end else begin
                            cur_read  <= req_read;
                            cur_len   <= req_len;
                            cur_addr  <= req_addr;
                            idx       <= '0;
                            stall_cnt <= '0;
                            err_code  <= XERR_NONE;
                            cs_n_q    <= 1'b0;
                            state     <= ST_LEAD;
                        end
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        state <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (sh_done) begin
                        if (idx == LEN_W'(HDR_BYTES - 1)) begin
                            idx   <= '0;
                            state <= ST_POLL;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (sh_done) begin
                        if (sh_rx[0]) begin
                            state <= ST_DATA;
                        end else if (stall_hit) begin
                            cs_n_q   <= 1'b1;
                            done     <= 1'b1;
                            err_code <= XERR_POLL;
                            gap_cnt  <= '0;
                            state    <= ST_GAP;
                        end else begin
                            stall_cnt <= stall_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sh_done) begin
                        if (cur_read) begin
                            rd_valid <= 1'b1;
                            rd_data  <= sh_rx;
                        end
                        if (last_payload) begin
                            cs_n_q  <= 1'b1;
                            done    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_cnt == GAP_CNT_W'(GAP_TICKS - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake and pin outputs.
    assign req_ready = (state == ST_IDLE);
    assign busy      = (state == ST_LEAD) || (state == ST_HDR) ||
                       (state == ST_POLL) || (state == ST_DATA);
    assign spi_cs_n  = cs_n_q;
    assign spi_sclk  = sh_sclk;
    assign spi_mosi  = sh_mosi;

    // R4: chip select rises only together with the done pulse.
    a_r4_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

    // R4: SCLK is never high with chip select released.
    a_r4_no_clock_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // R11: ready and busy are exclusive.
    a_r11_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && busy));

    // R11: an accepted request either starts or finishes at once.
    a_r11_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy || done));

    // R3: a refused length never lowers chip select.
    a_r3_reject_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !len_ok) |=> (spi_cs_n && (err_code == XERR_LEN)));

    // R6: read bytes only stream out of a read transaction.
    a_r6_rd_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> cur_read);

    // R7: write bytes are only taken during a write transaction.
    a_r7_take_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (!cur_read && !spi_cs_n));

endmodule

// File: tb/spi_regxact_master_test.sv
// Bench: a bit-level peripheral model with configurable stalls, a vector table
// of transactions, then directed cases for reset, refused lengths, poll limits
// and the handshake.
module spi_regxact_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [15:0] cfg_poll_limit = 16'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [6:0]  req_len = 7'd1;
    logic [23:0] req_addr = 24'd0;
    logic [7:0]  wr_data;
    logic        wr_take;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;
    logic        done;
    logic [1:0]  err_code;
    logic        spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    always #10 clk = ~clk;

    spi_regxact_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_poll_limit(cfg_poll_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_len(req_len), .req_addr(req_addr), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // {read, len, addr, stall bytes, divider}
    localparam logic [47:0] VEC [6] = '{
        {1'b1, 7'd4,  24'hD40018, 8'd1, 8'd1},
        {1'b0, 7'd4,  24'hD40018, 8'd0, 8'd1},
        {1'b1, 7'd64, 24'hD40024, 8'd3, 8'd0},
        {1'b0, 7'd64, 24'hD40024, 8'd2, 8'd2},
        {1'b0, 7'd1,  24'h000F00, 8'd0, 8'd0},
        {1'b1, 7'd1,  24'hFFFFFF, 8'd5, 8'd3}
    };

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] wbuf [0:63];
    logic [7:0] dev_rd [0:63];
    logic [7:0] cap [0:127];
    logic [7:0] rd_got [0:63];
    int dev_stalls = 0;
    int cap_n = 0;
    int rd_cnt = 0;
    int wr_idx = 0;
    int take_cnt = 0;
    int done_cnt = 0;
    int last_err = 0;
    int cs_at_done = 0;
    int cs_falls = 0;
    int sclk_bad = 0;
    int hi_run = 0;
    int gap_bad = 0;
    int gap_checks = 0;
    int gap_run = 0;
    int gap_div = 0;
    int have_rise = 0;
    logic cs_prev = 1'b1;
    int cyc = 0;

    assign wr_data = wbuf[wr_idx & 63];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Global watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Peripheral model: byte stream it returns at position n.
    function automatic logic [7:0] dev_byte_for(input int n);
        if (n < 4) return 8'h00;
        if ((n - 4) < dev_stalls) return 8'hFE;
        if ((n - 4) == dev_stalls) return 8'h55;
        return dev_rd[(n - 5 - dev_stalls) & 63];
    endfunction

    int dev_bit = 0;
    int dev_byte = 0;
    logic [7:0] dev_in = 8'h00;
    logic [7:0] dev_out = 8'h00;

    // Peripheral: restart on chip select fall and present the first bit.
    always @(negedge spi_cs_n) begin
        dev_bit = 0;
        dev_byte = 0;
        cap_n = 0;
        dev_out = dev_byte_for(0);
        spi_miso = dev_out[7];
    end

    // Peripheral: capture MOSI on rising SCLK.
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            dev_in = {dev_in[6:0], spi_mosi};
            dev_bit++;
            if (dev_bit == 8) begin
                cap[dev_byte & 127] = dev_in;
                dev_byte++;
                cap_n = dev_byte;
                dev_bit = 0;
            end
        end
    end

    // Peripheral: change MISO on falling SCLK.
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (dev_bit == 0) dev_out = dev_byte_for(dev_byte);
            spi_miso = dev_out[7 - dev_bit];
        end
    end

    // Output monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_cnt++;
                last_err = err_code;
                cs_at_done = spi_cs_n;
            end
            if (rd_valid) begin
                rd_got[rd_cnt & 63] = rd_data;
                rd_cnt++;
            end
            if (wr_take) begin
                take_cnt++;
                wr_idx++;
            end
            if (spi_sclk) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run != int'(cfg_div) + 1) sclk_bad++;
                hi_run = 0;
            end
            if (spi_cs_n) begin
                if (!cs_prev) begin
                    gap_div = cfg_div;
                    gap_run = 0;
                    have_rise = 1;
                end
                gap_run++;
            end else if (cs_prev) begin
                cs_falls++;
                if (have_rise) begin
                    gap_checks++;
                    if (gap_run < 4 * (gap_div + 1)) gap_bad++;
                end
            end
            cs_prev = spi_cs_n;
        end
    end

    task automatic wait_idle();
        int t = 0;
        while (!req_ready && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (!req_ready) chk(1'b0, "R11 watchdog idle", 0, 1);
    endtask

    // Issue one request and wait for done; poke offers a refused request mid-transfer.
    task automatic do_xact(input bit rd, input int len, input logic [23:0] addr,
                           input int stalls, input int div, input int limit,
                           input bit poke);
        int t;
        wait_idle();
        cfg_div = 8'(div);
        cfg_poll_limit = 16'(limit);
        dev_stalls = stalls;
        for (int i = 0; i < 64; i++) begin
            wbuf[i] = 8'((addr[7:0] ^ 8'hA5) + i * 29);
            dev_rd[i] = 8'((addr[15:8] ^ 8'h3C) + i * 53);
        end
        rd_cnt = 0; wr_idx = 0; take_cnt = 0; done_cnt = 0;
        req_read = rd; req_len = 7'(len); req_addr = addr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk); @(negedge clk);
            chk(busy && !req_ready, "R11 busy mid-transfer", {busy, req_ready}, 2'b10);
            req_len = 7'd0;
            req_valid = 1'b1;
            for (int k = 0; k < 10; k++) @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 40000) begin
            @(negedge clk);
            t++;
        end
        if (done_cnt == 0) chk(1'b0, "R4 watchdog done", 0, 1);
        @(negedge clk);
    endtask

    // Check a completed successful transaction against the request.
    task automatic check_xact(input bit rd, input int len, input logic [23:0] addr,
                              input int stalls);
        int bad;
        chk(cap[0] == {rd, 1'b1, 6'(len - 1)}, "R1 header byte0", cap[0], {rd, 1'b1, 6'(len - 1)});
        chk({cap[1], cap[2], cap[3]} == addr, "R2 address bytes", {cap[1], cap[2], cap[3]}, addr);
        chk(cap_n == 5 + stalls + len, "R5 byte count on wire", cap_n, 5 + stalls + len);
        bad = 0;
        for (int i = 4; i <= 4 + stalls; i++) if (cap[i] != 8'h00) bad++;
        chk(bad == 0, "R5 poll bytes are zero", bad, 0);
        chk(done_cnt == 1 && cs_at_done == 1, "R4 done with cs released", done_cnt, 1);
        chk(last_err == 0, "R6 success code", last_err, 0);
        bad = 0;
        if (rd) begin
            for (int i = 0; i < len; i++) begin
                if (rd_got[i] != dev_rd[i]) bad++;
                if (cap[5 + stalls + i] != 8'h00) bad++;
            end
            chk(rd_cnt == len, "R6 read byte count", rd_cnt, len);
            chk(bad == 0, "R6 read data", bad, 0);
        end else begin
            for (int i = 0; i < len; i++)
                if (cap[5 + stalls + i] != wbuf[i]) bad++;
            chk(take_cnt == len, "R7 take pulses", take_cnt, len);
            chk(bad == 0, "R7 write data", bad, 0);
        end
    endtask

    initial begin
        int falls0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R4 reset pins", {spi_cs_n, spi_sclk}, 2'b10);
        chk(req_ready && !busy && !done, "R11 reset handshake", {req_ready, busy, done}, 3'b100);

        // Table of transactions.
        for (int v = 0; v < 6; v++) begin
            logic [47:0] e;
            e = VEC[v];
            do_xact(e[47], int'(e[46:40]), e[39:16], int'(e[15:8]), int'(e[7:0]), 0, 1'b0);
            check_xact(e[47], int'(e[46:40]), e[39:16], int'(e[15:8]));
        end

        // R3: refused lengths 0 and 65.
        falls0 = cs_falls;
        do_xact(1'b1, 0, 24'h000018, 0, 1, 0, 1'b0);
        chk(last_err == 1 && done_cnt == 1, "R3 zero length refused", last_err, 1);
        do_xact(1'b0, 65, 24'h000018, 0, 1, 0, 1'b0);
        chk(last_err == 1 && done_cnt == 1, "R3 length 65 refused", last_err, 1);
        chk(cs_falls == falls0 && take_cnt == 0, "R3 no bus activity", cs_falls - falls0, 0);

        // R8: limit equal to the stall count aborts.
        do_xact(1'b1, 8, 24'h001234, 3, 1, 3, 1'b0);
        chk(last_err == 2, "R8 poll abort code", last_err, 2);
        chk(cap_n == 7 && rd_cnt == 0, "R8 abort bytes on wire", cap_n, 7);
        chk(cs_at_done == 1, "R8 cs released on abort", cs_at_done, 1);
        // R8: limit one above the stall count succeeds.
        do_xact(1'b1, 8, 24'h001234, 3, 1, 4, 1'b0);
        check_xact(1'b1, 8, 24'h001234, 3);
        // R8: limit 0 means unlimited.
        do_xact(1'b0, 3, 24'h00ABCD, 12, 0, 0, 1'b0);
        check_xact(1'b0, 3, 24'h00ABCD, 12);

        // R11: request offered while busy is ignored.
        do_xact(1'b0, 6, 24'h0F0F0F, 2, 1, 0, 1'b1);
        check_xact(1'b0, 6, 24'h0F0F0F, 2);

        // R9 and R10 across all traffic.
        wait_idle();
        chk(sclk_bad == 0, "R9 SCLK high phase length", sclk_bad, 0);
        chk(gap_bad == 0 && gap_checks > 5, "R10 chip select gap", gap_bad, 0);

        finish_run();
    end

endmodule